// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer reached through a small word-addressed register port. A down-counter runs on every system clock or on a 1 MHz tick pulse, chosen by a control bit. Software keeps it alive by writing one key value to a restart register. Any other value written there has no effect. If the counter is allowed to run out, the block records a timeout and reloads itself. When resets are enabled, it also raises a reset request for a programmable number of cycles.

Each reset request carries a 2-bit scope code and a 25-bit peripheral mask. The reset distribution network reads these to decide what to reset. An optional alternate-boot flag accompanies the request. The mask register resets to a default that covers every domain except the memory, bus fabric, management transport, DMA and serial flash domains. The network that acts on the request is outside this block.

Top module: `keyed_wdt`

## Requirements
- R1: Register index map: 0 control, 1 reload, 2 restart (reads 0), 3 live count (read only), 4 timeout status, 5 status clear (reads 0), 6 reset pulse width, 7 reset mask. After reset, control reads 0, reload and count read RELOAD_INIT (default 1000), status reads 0 and pulse width reads PULSE_INIT (default 16).
- R2: Control bits: bit 0 enables counting, bit 1 enables the reset request, bit 4 selects the tick input instead of the system clock, bits 6:5 hold the scope code (0 SoC, 1 full chip, 2 CPU only), bit 7 requests an alternate boot. Bits 2 and 3 are not stored and read 0.
- R3: While enabled, the count drops by one on every clock when bit 4 is 0. When bit 4 is 1, it drops only on clocks where `usTick` is high.
- R4: While disabled, the count holds its value.
- R5: Writing 0x4755 to the restart register loads the count from the reload register at that clock edge, whatever the enable. Any other value written there leaves the count unchanged. A restart takes priority over a tick in the same cycle.
- R6: A tick that finds the count at 0 is an expiry. The expiry reloads the count, sets status bit 0 and increments the 8-bit timeout counter in status bits 15:8.
- R7: Any write to the clear register clears status bit 0 and leaves the timeout counter unchanged. An expiry in the same cycle wins and sets the bit.
- R8: At an expiry with control bit 1 set, `rstReq` goes high from the next cycle for `width` cycles, or for 1 cycle if `width` is 0. With bit 1 clear, no request is raised.
- R9: At that expiry, `rstMode` takes the scope code and `rstMask` takes the mask register. Both hold while `rstReq` is high. `altBoot` is high with `rstReq` when control bit 7 was set at the expiry.
- R10: The mask register holds 25 bits and resets to 0x03FFFF3. In that value bits 2, 3 and 22 to 24 are clear and all the others are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register index for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the register at `addr` (combinational) |
| usTick | input | 1 | 1 MHz tick pulse, one clock wide |
| rstReq | output | 1 | Reset request pulse |
| rstMode | output | 2 | Scope code captured at expiry |
| rstMask | output | MASK_W | Peripheral mask captured at expiry |
| altBoot | output | 1 | Alternate-boot request, high with `rstReq` |

## Verification
The assertions check five rules on every cycle. A key write reloads the count from the reload value. A wrong key or a disabled counter leaves the count unchanged. Every expiry sets the timeout flag. A reset request only rises when resets were enabled, and its scope and mask stay steady for the whole pulse. Other properties need whole scenarios that only the bench can drive: the exact cycle of expiry after a restart, the pulse length for a given width, counting on the slow tick, and a clear racing an expiry. The bench checks these against a reference model that it keeps itself, under random register traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;
  localparam logic [DATA_W-1:0] MASK_DEFAULT = 32'h003F_FFF3;

  // control bit positions
  localparam int CB_EN = 0;
  localparam int CB_RSTEN = 1;
  localparam int CB_USTICK = 4;
  localparam int CB_MODE = 5;
  localparam int CB_ALT = 7;
  localparam logic [7:0] CTRL_WMASK = 8'hF3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_RELOAD = 3'd1,
    REG_KICK = 3'd2,
    REG_COUNT = 3'd3,
    REG_STATUS = 3'd4,
    REG_CLEAR = 3'd5,
    REG_WIDTH = 3'd6,
    REG_MASK = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic kick;
    logic clrFlag;
    logic tick;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl import wdt_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int PULSE_W = 8,
  parameter int TOCNT_W = 8,
  parameter int MASK_W = 25,
  parameter int RELOAD_INIT = 1000,
  parameter int PULSE_INIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic usTick,
  input  logic [CNT_W-1:0] cnt,
  input  logic toFlag,
  input  logic [TOCNT_W-1:0] toCount,
  output logic [DATA_W-1:0] rdData,
  output wdtStrobe_t strobe,
  output logic rstEn,
  output logic [1:0] modeSel,
  output logic altSel,
  output logic [CNT_W-1:0] reloadVal,
  output logic [PULSE_W-1:0] pulseWidth,
  output logic [MASK_W-1:0] maskVal
);
  localparam int STAT_CNT_LSB = 8;

  logic [7:0] ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      reloadVal <= CNT_W'(RELOAD_INIT);
      pulseWidth <= PULSE_W'(PULSE_INIT);
      maskVal <= MASK_DEFAULT[MASK_W-1:0];
    end else if (wrEn) begin
      case (regIdx_e'(addr))
        REG_CTRL: ctrlQ <= wrData[7:0] & CTRL_WMASK;
        REG_RELOAD: reloadVal <= wrData[CNT_W-1:0];
        REG_WIDTH: pulseWidth <= wrData[PULSE_W-1:0];
        REG_MASK: maskVal <= wrData[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.kick = wrEn && (regIdx_e'(addr) == REG_KICK) && (wrData == RESTART_KEY);
    strobe.clrFlag = wrEn && (regIdx_e'(addr) == REG_CLEAR);
    strobe.tick = ctrlQ[CB_EN] && (ctrlQ[CB_USTICK] ? usTick : 1'b1);
  end

  assign rstEn = ctrlQ[CB_RSTEN];
  assign modeSel = ctrlQ[CB_MODE +: 2];
  assign altSel = ctrlQ[CB_ALT];

  always_comb begin
    rdData = '0;
    case (regIdx_e'(addr))
      REG_CTRL: rdData[7:0] = ctrlQ;
      REG_RELOAD: rdData[CNT_W-1:0] = reloadVal;
      REG_COUNT: rdData[CNT_W-1:0] = cnt;
      REG_STATUS: begin
        rdData[0] = toFlag;
        rdData[STAT_CNT_LSB +: TOCNT_W] = toCount;
      end
      REG_WIDTH: rdData[PULSE_W-1:0] = pulseWidth;
      REG_MASK: rdData[MASK_W-1:0] = maskVal;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath import wdt_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int PULSE_W = 8,
  parameter int TOCNT_W = 8,
  parameter int MASK_W = 25,
  parameter int RELOAD_INIT = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  wdtStrobe_t strobe,
  input  logic rstEn,
  input  logic [1:0] modeSel,
  input  logic altSel,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [PULSE_W-1:0] pulseWidth,
  input  logic [MASK_W-1:0] maskVal,
  output logic [CNT_W-1:0] cnt,
  output logic toFlag,
  output logic [TOCNT_W-1:0] toCount,
  output logic rstReq,
  output logic [1:0] rstMode,
  output logic [MASK_W-1:0] rstMask,
  output logic altBoot
);
  logic expire;
  logic fire;
  logic altQ;
  logic [PULSE_W-1:0] pulseCnt;

  assign expire = strobe.tick && !strobe.kick && (cnt == '0);
  assign fire = expire && rstEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(RELOAD_INIT);
      toFlag <= 1'b0;
      toCount <= '0;
    end else begin
      if (strobe.kick || expire) cnt <= reloadVal;
      else if (strobe.tick) cnt <= cnt - CNT_W'(1);
      if (expire) toFlag <= 1'b1;
      else if (strobe.clrFlag) toFlag <= 1'b0;
      if (expire) toCount <= toCount + TOCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      rstMode <= '0;
      rstMask <= '0;
      altQ <= 1'b0;
    end else if (fire) begin
      pulseCnt <= (pulseWidth == '0) ? PULSE_W'(1) : pulseWidth;
      rstMode <= modeSel;
      rstMask <= maskVal;
      altQ <= altSel;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  assign rstReq = (pulseCnt != '0);
  assign altBoot = rstReq && altQ;

  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rstN) strobe.kick |=> (cnt == $past(reloadVal))); // R5
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN) (!strobe.kick && !strobe.tick) |=> $stable(cnt)); // R4
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN) expire |=> toFlag); // R6
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) $rose(rstReq) |-> $past(rstEn)); // R8
  AST_SCOPE_STABLE: assert property (@(posedge clk) disable iff (!rstN) (rstReq && $past(rstReq) && !$past(fire)) |-> ($stable(rstMode) && $stable(rstMask))); // R9
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt import wdt_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int PULSE_W = 8,
  parameter int TOCNT_W = 8,
  parameter int MASK_W = 25,
  parameter int RELOAD_INIT = 1000,
  parameter int PULSE_INIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [2:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic usTick,
  output logic rstReq,
  output logic [1:0] rstMode,
  output logic [MASK_W-1:0] rstMask,
  output logic altBoot
);
  wdtStrobe_t strobe;
  logic rstEn, altSel, toFlag;
  logic [1:0] modeSel;
  logic [CNT_W-1:0] reloadVal, cnt;
  logic [PULSE_W-1:0] pulseWidth;
  logic [MASK_W-1:0] maskVal;
  logic [TOCNT_W-1:0] toCount;

  wdt_ctrl #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .TOCNT_W(TOCNT_W), .MASK_W(MASK_W),
             .RELOAD_INIT(RELOAD_INIT), .PULSE_INIT(PULSE_INIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .usTick(usTick),
    .cnt(cnt), .toFlag(toFlag), .toCount(toCount), .rdData(rdData), .strobe(strobe),
    .rstEn(rstEn), .modeSel(modeSel), .altSel(altSel), .reloadVal(reloadVal),
    .pulseWidth(pulseWidth), .maskVal(maskVal)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .TOCNT_W(TOCNT_W), .MASK_W(MASK_W),
                 .RELOAD_INIT(RELOAD_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rstEn(rstEn), .modeSel(modeSel),
    .altSel(altSel), .reloadVal(reloadVal), .pulseWidth(pulseWidth), .maskVal(maskVal),
    .cnt(cnt), .toFlag(toFlag), .toCount(toCount), .rstReq(rstReq), .rstMode(rstMode),
    .rstMask(rstMask), .altBoot(altBoot)
  );

  AST_WRONG_KEY: assert property (@(posedge clk) disable iff (!rstN) (wrEn && addr == REG_KICK && wrData != RESTART_KEY && !strobe.tick) |=> $stable(cnt)); // R5
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam logic [31:0] KEY = 32'h4755;
  localparam logic [31:0] DEF_MASK = 32'h003F_FFF3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic usTick = 1'b0;
  logic [31:0] rdData;
  logic rstReq, altBoot;
  logic [1:0] rstMode;
  logic [24:0] rstMask;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .usTick(usTick), .rstReq(rstReq), .rstMode(rstMode), .rstMask(rstMask), .altBoot(altBoot)
  );

  // reference model built from the requirements
  logic [31:0] mCount, mReload;
  logic [7:0] mCtrl, mWidth, mPulse, mToCnt;
  logic mFlag, mAlt;
  logic [24:0] mMask, mOutMask;
  logic [1:0] mMode;

  always @(posedge clk or negedge rstN) begin : mdl
    logic tk, kk, ex;
    if (!rstN) begin
      mCount <= 32'd1000; mReload <= 32'd1000; mCtrl <= '0; mWidth <= 8'd16;
      mMask <= DEF_MASK[24:0]; mFlag <= 1'b0; mToCnt <= '0; mPulse <= '0;
      mMode <= '0; mOutMask <= '0; mAlt <= 1'b0;
    end else begin
      tk = mCtrl[0] && (mCtrl[4] ? usTick : 1'b1);
      kk = wrEn && addr == 3'd2 && wrData == KEY;
      ex = tk && !kk && mCount == 0;
      if (kk || ex) mCount <= mReload;
      else if (tk) mCount <= mCount - 1;
      if (ex) mFlag <= 1'b1;
      else if (wrEn && addr == 3'd5) mFlag <= 1'b0;
      if (ex) mToCnt <= mToCnt + 1;
      if (ex && mCtrl[1]) begin
        mPulse <= (mWidth == 0) ? 8'd1 : mWidth;
        mMode <= mCtrl[6:5]; mOutMask <= mMask; mAlt <= mCtrl[7];
      end else if (mPulse != 0) mPulse <= mPulse - 1;
      if (wrEn) begin
        case (addr)
          3'd0: mCtrl <= wrData[7:0] & 8'hF3;
          3'd1: mReload <= wrData;
          3'd6: mWidth <= wrData[7:0];
          3'd7: mMask <= wrData[24:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {24'b0, mCtrl};
      3'd1: return mReload;
      3'd3: return mCount;
      3'd4: return {16'b0, mToCnt, 7'b0, mFlag};
      3'd6: return {24'b0, mWidth};
      3'd7: return {7'b0, mMask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0: return "R2 control";
      3'd3: return "R3 count";
      3'd4: return "R6 status";
      3'd7: return "R10 mask";
      default: return "R1 register";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model, between edges
  always begin
    @(posedge clk); #1;
    if (rstN) begin
      chk(tagFor(addr), rdData, modelRead(addr));
      chk("R8 rstReq", {31'b0, rstReq}, {31'b0, (mPulse != 0)});
      chk("R9 altBoot", {31'b0, altBoot}, {31'b0, (mPulse != 0) && mAlt});
      if (rstReq) begin
        chk("R9 rstMode", {30'b0, rstMode}, {30'b0, mMode});
        chk("R9 rstMask", {7'b0, rstMask}, {7'b0, mOutMask});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] v);
    wrEn = 1'b0; addr = a; #1; v = rdData;
  endtask

  initial begin
    logic [31:0] v;
    int n, hi;
    logic sawReq;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // reset state (R1, R10)
    readReg(3'd0, v); chk("R1 ctrl reset", v, 32'h0);
    readReg(3'd1, v); chk("R1 reload reset", v, 32'd1000);
    readReg(3'd3, v); chk("R1 count reset", v, 32'd1000);
    readReg(3'd4, v); chk("R1 status reset", v, 32'h0);
    readReg(3'd6, v); chk("R1 width reset", v, 32'd16);
    readReg(3'd7, v); chk("R10 mask reset", v, DEF_MASK);

    // expiry timing and pulse (R5, R6, R8, R9, R2)
    writeReg(3'd1, 32'd5);
    writeReg(3'd6, 32'd3);
    writeReg(3'd7, 32'h0155_AA0F);
    writeReg(3'd0, 32'hC3);
    writeReg(3'd2, KEY);
    readReg(3'd3, v); chk("R5 key reload", v, 32'd5);
    n = 0;
    while (!rstReq && n < 50) begin step(); n++; end
    chk("R6 expiry cycle", n, 6);
    chk("R9 mode at pulse", {30'b0, rstMode}, 32'd2);
    chk("R9 mask at pulse", {7'b0, rstMask}, 32'h0155_AA0F);
    chk("R9 alt boot", {31'b0, altBoot}, 32'd1);
    hi = 1; step();
    while (rstReq && hi < 50) begin hi++; step(); end
    chk("R8 pulse width", hi, 3);
    writeReg(3'd0, 32'h0);

    // wrong key and hold (R5, R4)
    writeReg(3'd1, 32'd9);
    writeReg(3'd2, 32'h4756);
    readReg(3'd3, v); chk("R5 wrong key ignored", v, 32'd1);
    writeReg(3'd2, KEY);
    repeat (10) step();
    readReg(3'd3, v); chk("R4 hold when disabled", v, 32'd9);

    // tick mode, no reset when disabled, clear (R3, R6, R8, R7)
    writeReg(3'd0, 32'h11);
    for (int i = 0; i < 3; i++) begin
      usTick = 1'b1; step(); usTick = 1'b0; step(); step();
    end
    readReg(3'd3, v); chk("R3 tick-mode count", v, 32'd6);
    sawReq = 1'b0;
    for (int i = 0; i < 7; i++) begin
      usTick = 1'b1; step(); sawReq |= rstReq; usTick = 1'b0; step(); sawReq |= rstReq;
    end
    readReg(3'd4, v); chk("R6 flag and count", v, 32'h201);
    chk("R8 no request when off", {31'b0, sawReq}, 32'd0);
    readReg(3'd3, v); chk("R6 reload on expiry", v, 32'd9);
    writeReg(3'd5, 32'hDEAD);
    readReg(3'd4, v); chk("R7 clear keeps count", v, 32'h200);
    writeReg(3'd0, 32'hFF);
    readReg(3'd0, v); chk("R2 reserved bits", v, 32'hF3);

    // constrained random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      usTick = ($urandom % 3) == 0;
      if (($urandom % 8) < 2) begin
        wrEn = 1'b1; addr = a;
        case (a)
          3'd0: wrData = $urandom & 32'hFF;
          3'd1: wrData = $urandom % 24;
          3'd2: wrData = ($urandom % 2) ? KEY : $urandom;
          3'd6: wrData = $urandom % 6;
          default: wrData = $urandom;
        endcase
      end else begin
        wrEn = 1'b0; addr = a; wrData = '0;
      end
      step();
    end
    wrEn = 1'b0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule